// File: doc/BRIEF.md
# Sprite Attribute Copy Engine with CPU Lockout

This block copies a fixed run of 160 bytes from a page of the CPU address space into sprite attribute memory. A single start strobe carries a 16-bit base address. After a fixed start-up delay the engine issues one read request per byte on the system bus and, one cycle after each read, writes the returned byte into attribute memory at an index that counts up from zero. Bytes are spaced a fixed number of cycles apart. A start strobe that arrives while a copy is running abandons that copy and begins a new one from the new base.

While a copy is in flight, the CPU cannot reach two address ranges. One is the attribute memory window. The other is a region chosen from the top three bits of the current source address, using a table that differs between an older and a newer hardware model. The engine contains the gate that the CPU-side decoder uses: inside a locked range, read data is replaced with 0xFF and write strobes are suppressed. Outside those ranges, reads and writes pass through unchanged.

Top module: `oam_dma_engine`

## Requirements
- R1: A start strobe is accepted only when `base_i` is at most 0xF100. A strobe with a larger base has no effect, whether the engine is idle or already copying.
- R2: Call the clock edge that samples an accepted start E0. `bus_req_o` is high in the cycles that begin at E(7+4k), and `oam_we_o` is high in the cycles that begin at E(8+4k), for k = 0..159. Neither is high in any other cycle.
- R3: In request k, `bus_addr_o` equals base+k. In write k, `oam_addr_o` equals k and `oam_wdata_o` equals the `bus_data_i` value sampled at the end of request k.
- R4: `busy_o` is low after reset. It is high from the cycle after E0 through the cycle of the last write, and it falls in the next cycle.
- R5: An accepted start during a copy restarts the schedule from the new base, with the index back at 0. If that start is sampled at the end of a request cycle, that byte is never written. A write already in progress in the start cycle still completes.
- R6: While `busy_o` is high, CPU addresses 0xFE00 to 0xFE9F are locked.
- R7: With `model_new_i` low, source bits [15:13] equal to 4 lock 0x8000 to 0x9FFF. Every other value locks 0xA000 to 0xFDFF.
- R8: With `model_new_i` high, source bits [15:13] equal to 4 lock 0x8000 to 0x9FFF, and 6 locks 0xC000 to 0xFDFF. Every other value locks 0xA000 to 0xBFFF.
- R9: For a locked address, `cpu_locked_o` is 1, `cpu_rdata_o` is 0xFF and `cpu_wr_o` is 0. Otherwise `cpu_locked_o` is 0, `cpu_rdata_o` equals `cpu_rdata_i` and `cpu_wr_o` equals `cpu_wr_i`.
- R10: The region lock follows the current source address, which advances by one after each request. It is not fixed by the starting base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe |
| base_i | input | 16 | Source base address carried with the start strobe |
| model_new_i | input | 1 | Selects the newer model's lock table |
| bus_req_o | output | 1 | System bus read request |
| bus_addr_o | output | 16 | Source address of the current read |
| bus_data_i | input | DATA_W | Read data, sampled at the end of a request cycle |
| oam_we_o | output | 1 | Attribute memory write enable |
| oam_addr_o | output | log2(OAM_DEPTH) | Attribute memory write index |
| oam_wdata_o | output | DATA_W | Attribute memory write data |
| busy_o | output | 1 | Copy in progress |
| cpu_addr_i | input | 16 | CPU access address |
| cpu_wr_i | input | 1 | CPU write strobe from the decoder |
| cpu_rdata_i | input | DATA_W | CPU read data from the decoder |
| cpu_rdata_o | output | DATA_W | CPU read data after lockout |
| cpu_wr_o | output | 1 | CPU write strobe after lockout |
| cpu_locked_o | output | 1 | Current CPU address is locked |

## Verification
Two events can land in the same cycle: a restart strobe and a pending byte step. The bench sends a restart in the exact cycle that a read request is on the bus. It then checks that no write follows one cycle later and that the new schedule, starting at index 0 with the new base, is correct cycle by cycle. A second restart is sent in a write cycle. There the bench checks that the old write still happens and that the next write carries index 0. An over-range start is also sent in the middle of a copy, and the bench checks that the running schedule continues unchanged.

// File: rtl/oam_dma_pkg.sv
`timescale 1ns/1ps
package oam_dma_pkg;
   localparam int ADDR_W = 16;

   typedef struct packed {
      logic [ADDR_W-1:0] lo;
      logic [ADDR_W-1:0] hi;   // exclusive bound
   } lock_win_t;

   function automatic lock_win_t region_window(input logic [2:0] idx, input logic newer);
      lock_win_t w;
      if (idx == 3'd4) begin
         w.lo = 16'h8000; w.hi = 16'hA000;
      end else if (newer && idx == 3'd6) begin
         w.lo = 16'hC000; w.hi = 16'hFE00;
      end else if (newer) begin
         w.lo = 16'hA000; w.hi = 16'hC000;
      end else begin
         w.lo = 16'hA000; w.hi = 16'hFE00;
      end
      return w;
   endfunction
endpackage

// File: rtl/oam_dma_pacer.sv
`timescale 1ns/1ps
module oam_dma_pacer #(
   parameter int XFER_LEN    = 160,
   parameter int START_DELAY = 8,
   parameter int STEP_GAP    = 4,
   parameter logic [15:0] MAX_BASE = 16'hF100
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic [15:0] base_i,
   output logic        accept_o,
   output logic        req_o,
   output logic        step_o,
   output logic        running_o,
   output logic [15:0] src_o
);
   localparam int CNT_W = $clog2(XFER_LEN + 1);
   localparam int TMR_W = $clog2(START_DELAY);
   localparam logic [CNT_W-1:0] LEN_V   = CNT_W'(XFER_LEN);
   localparam logic [TMR_W-1:0] FIRST_V = TMR_W'(START_DELAY - 1);
   localparam logic [TMR_W-1:0] GAP_V   = TMR_W'(STEP_GAP - 1);

   logic [CNT_W-1:0] left_q;
   logic [TMR_W-1:0] tmr_q;
   logic [15:0]      src_q;

   assign accept_o  = start_i && (base_i <= MAX_BASE);
   assign running_o = (left_q != '0);
   assign req_o     = running_o && (tmr_q == '0);
   assign step_o    = req_o && !accept_o;
   assign src_o     = src_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
         tmr_q  <= '0;
         src_q  <= '0;
      end else if (accept_o) begin
         left_q <= LEN_V;
         tmr_q  <= FIRST_V;
         src_q  <= base_i;
      end else if (running_o) begin
         if (tmr_q == '0) begin
            left_q <= left_q - 1'b1;
            tmr_q  <= GAP_V;
            src_q  <= src_q + 16'd1;
         end else begin
            tmr_q  <= tmr_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/oam_dma_writer.sv
`timescale 1ns/1ps
module oam_dma_writer #(
   parameter int DATA_W    = 8,
   parameter int OAM_DEPTH = 256
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         accept_i,
   input  logic                         step_i,
   input  logic [DATA_W-1:0]            rd_data_i,
   output logic                         we_o,
   output logic [$clog2(OAM_DEPTH)-1:0] idx_o,
   output logic [DATA_W-1:0]            wdata_o
);
   localparam int IDX_W = $clog2(OAM_DEPTH);

   logic              we_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         we_q   <= 1'b0;
         idx_q  <= '0;
         data_q <= '0;
      end else begin
         we_q <= step_i;
         if (step_i) data_q <= rd_data_i;
         if (accept_i)  idx_q <= '0;
         else if (we_q) idx_q <= idx_q + 1'b1;
      end
   end

   assign we_o    = we_q;
   assign idx_o   = idx_q;
   assign wdata_o = data_q;
endmodule

// File: rtl/oam_dma_lockmap.sv
`timescale 1ns/1ps
module oam_dma_lockmap
   import oam_dma_pkg::*;
#(
   parameter logic [15:0] OAM_LO = 16'hFE00,
   parameter logic [15:0] OAM_HI = 16'hFEA0
) (
   input  logic        active_i,
   input  logic        model_new_i,
   input  logic [15:0] src_i,
   input  logic [15:0] cpu_addr_i,
   output logic        locked_o
);
   lock_win_t win;
   logic      in_win, in_oam;

   always_comb begin
      win    = region_window(src_i[15:13], model_new_i);
      in_win = (cpu_addr_i >= win.lo) && (cpu_addr_i < win.hi);
      in_oam = (cpu_addr_i >= OAM_LO) && (cpu_addr_i < OAM_HI);
      locked_o = active_i && (in_win || in_oam);
   end
endmodule

// File: rtl/oam_dma_cpu_gate.sv
`timescale 1ns/1ps
module oam_dma_cpu_gate #(
   parameter int DATA_W = 8
) (
   input  logic              locked_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic              wr_o,
   output logic [DATA_W-1:0] rdata_o
);
   assign wr_o    = wr_i && !locked_i;
   assign rdata_o = locked_i ? {DATA_W{1'b1}} : rdata_i;
endmodule

// File: rtl/oam_dma_engine.sv
`timescale 1ns/1ps
module oam_dma_engine #(
   parameter int DATA_W      = 8,
   parameter int XFER_LEN    = 160,
   parameter int OAM_DEPTH   = 256,
   parameter int START_DELAY = 8,
   parameter int STEP_GAP    = 4,
   parameter logic [15:0] MAX_BASE = 16'hF100
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start_i,
   input  logic [15:0]                  base_i,
   input  logic                         model_new_i,
   output logic                         bus_req_o,
   output logic [15:0]                  bus_addr_o,
   input  logic [DATA_W-1:0]            bus_data_i,
   output logic                         oam_we_o,
   output logic [$clog2(OAM_DEPTH)-1:0] oam_addr_o,
   output logic [DATA_W-1:0]            oam_wdata_o,
   output logic                         busy_o,
   input  logic [15:0]                  cpu_addr_i,
   input  logic                         cpu_wr_i,
   input  logic [DATA_W-1:0]            cpu_rdata_i,
   output logic [DATA_W-1:0]            cpu_rdata_o,
   output logic                         cpu_wr_o,
   output logic                         cpu_locked_o
);
   localparam logic [15:0] OAM_LO = 16'hFE00;
   localparam logic [15:0] OAM_HI = 16'(32'hFE00 + XFER_LEN);

   if (XFER_LEN < 1 || XFER_LEN > OAM_DEPTH) begin : g_bad_len
      $error("oam_dma_engine: XFER_LEN must lie in 1..OAM_DEPTH");
   end
   if (STEP_GAP < 2) begin : g_bad_gap
      $error("oam_dma_engine: STEP_GAP must be at least 2");
   end
   if (START_DELAY < STEP_GAP) begin : g_bad_delay
      $error("oam_dma_engine: START_DELAY must not be below STEP_GAP");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("oam_dma_engine: DATA_W must be positive");
   end

   logic accept, step, running, locked;
   logic [15:0] src;

   oam_dma_pacer #(
      .XFER_LEN(XFER_LEN), .START_DELAY(START_DELAY),
      .STEP_GAP(STEP_GAP), .MAX_BASE(MAX_BASE)
   ) u_pacer (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
      .accept_o(accept), .req_o(bus_req_o), .step_o(step),
      .running_o(running), .src_o(src)
   );

   oam_dma_writer #(.DATA_W(DATA_W), .OAM_DEPTH(OAM_DEPTH)) u_writer (
      .clk(clk), .rst_n(rst_n), .accept_i(accept), .step_i(step),
      .rd_data_i(bus_data_i), .we_o(oam_we_o), .idx_o(oam_addr_o),
      .wdata_o(oam_wdata_o)
   );

   assign busy_o     = running || oam_we_o;
   assign bus_addr_o = src;

   oam_dma_lockmap #(.OAM_LO(OAM_LO), .OAM_HI(OAM_HI)) u_lock (
      .active_i(busy_o), .model_new_i(model_new_i), .src_i(src),
      .cpu_addr_i(cpu_addr_i), .locked_o(locked)
   );

   oam_dma_cpu_gate #(.DATA_W(DATA_W)) u_gate (
      .locked_i(locked), .wr_i(cpu_wr_i), .rdata_i(cpu_rdata_i),
      .wr_o(cpu_wr_o), .rdata_o(cpu_rdata_o)
   );

   assign cpu_locked_o = locked;
endmodule

// File: rtl/oam_dma_engine_chk.sv
`timescale 1ns/1ps
module oam_dma_engine_chk #(
   parameter int DATA_W    = 8,
   parameter int XFER_LEN  = 160,
   parameter int IDX_W     = 8,
   parameter logic [15:0] MAX_BASE = 16'hF100
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [15:0]       base_i,
   input logic              bus_req_o,
   input logic              oam_we_o,
   input logic [IDX_W-1:0]  oam_addr_o,
   input logic              busy_o,
   input logic              cpu_wr_o,
   input logic [DATA_W-1:0] cpu_rdata_o,
   input logic              cpu_locked_o
);
   logic good_start;
   assign good_start = start_i && (base_i <= MAX_BASE);

   a_r2_write_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && !good_start) |=> oam_we_o);
   a_r5_restart_drops_step: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && good_start) |=> !oam_we_o);
   a_r2_single_write: assert property (@(posedge clk) disable iff (!rst_n)
      oam_we_o |=> !oam_we_o);
   a_r1_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && base_i > MAX_BASE && !busy_o) |=> !busy_o);
   a_r3_index_range: assert property (@(posedge clk) disable iff (!rst_n)
      oam_we_o |-> (int'(oam_addr_o) < XFER_LEN));
   a_r6_idle_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !cpu_locked_o);
   a_r9_read_forced: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_locked_o |-> (cpu_rdata_o == {DATA_W{1'b1}} && !cpu_wr_o));
endmodule

bind oam_dma_engine oam_dma_engine_chk #(
   .DATA_W(DATA_W), .XFER_LEN(XFER_LEN),
   .IDX_W($clog2(OAM_DEPTH)), .MAX_BASE(MAX_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
   .bus_req_o(bus_req_o), .oam_we_o(oam_we_o), .oam_addr_o(oam_addr_o),
   .busy_o(busy_o), .cpu_wr_o(cpu_wr_o), .cpu_rdata_o(cpu_rdata_o),
   .cpu_locked_o(cpu_locked_o)
);

// File: tb/oam_dma_engine_tb_top.sv
`timescale 1ns/1ps
module oam_dma_engine_tb_top;
   localparam int LEN = 160;
   localparam int LAST_W = 8 + 4 * (LEN - 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [15:0] base_i = '0;
   logic model_new_i = 1'b0;
   logic bus_req_o, oam_we_o, busy_o, cpu_wr_o, cpu_locked_o;
   logic [15:0] bus_addr_o;
   logic [7:0] bus_data_i, oam_addr_o, oam_wdata_o, cpu_rdata_o;
   logic [15:0] cpu_addr_i = '0;
   logic cpu_wr_i = 1'b1;
   logic [7:0] cpu_rdata_i = 8'h3C;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   function automatic logic [7:0] src_byte(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction
   assign bus_data_i = src_byte(bus_addr_o);

   oam_dma_engine dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
      .model_new_i(model_new_i), .bus_req_o(bus_req_o), .bus_addr_o(bus_addr_o),
      .bus_data_i(bus_data_i), .oam_we_o(oam_we_o), .oam_addr_o(oam_addr_o),
      .oam_wdata_o(oam_wdata_o), .busy_o(busy_o), .cpu_addr_i(cpu_addr_i),
      .cpu_wr_i(cpu_wr_i), .cpu_rdata_i(cpu_rdata_i), .cpu_rdata_o(cpu_rdata_o),
      .cpu_wr_o(cpu_wr_o), .cpu_locked_o(cpu_locked_o)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic bit exp_lock(input logic [15:0] a, input logic [15:0] src,
                                   input bit newer);
      logic [2:0] idx;
      int lo, hi;
      idx = src[15:13];
      if (a >= 16'hFE00 && a < 16'hFEA0) return 1'b1;
      if (idx == 3'd4) begin lo = 'h8000; hi = 'hA000; end
      else if (newer && idx == 3'd6) begin lo = 'hC000; hi = 'hFE00; end
      else if (newer) begin lo = 'hA000; hi = 'hC000; end
      else begin lo = 'hA000; hi = 'hFE00; end
      return (int'(a) >= lo) && (int'(a) < hi);
   endfunction

   // caller sits at a negedge; start is sampled at the next posedge (E0)
   task automatic kick(input logic [15:0] base);
      start_i = 1'b1;
      base_i  = base;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   // check cycles from..to-1 after E0 of base; optional bad start at ign_at
   task automatic run_sched(input logic [15:0] base, input int from, input int upto,
                            input int ign_at);
      for (int cyc = from; cyc < upto; cyc++) begin
         bit rq, wr;
         int k;
         rq = (cyc >= 7) && ((cyc - 7) % 4 == 0) && ((cyc - 7) / 4 < LEN);
         wr = (cyc >= 8) && ((cyc - 8) % 4 == 0) && ((cyc - 8) / 4 < LEN);
         chk("R2", "bus_req", 32'(bus_req_o), 32'(rq));
         chk("R2", "oam_we", 32'(oam_we_o), 32'(wr));
         chk("R4", "busy", 32'(busy_o), 32'(cyc <= LAST_W));
         if (rq) begin
            k = (cyc - 7) / 4;
            chk("R3", "bus_addr", 32'(bus_addr_o), 32'(base + 16'(k)));
         end
         if (wr) begin
            k = (cyc - 8) / 4;
            chk("R3", "oam_addr", 32'(oam_addr_o), 32'(k));
            chk("R3", "oam_wdata", 32'(oam_wdata_o), 32'(src_byte(base + 16'(k))));
         end
         if (cyc == ign_at) begin
            start_i = 1'b1; base_i = 16'hF200;   // R1: over-range while running
         end else begin
            start_i = 1'b0;
         end
         @(negedge clk);
      end
      start_i = 1'b0;
   endtask

   task automatic probe_set(input logic [15:0] src, input bit newer, input bit act,
                            input string req);
      logic [15:0] pts [12] = '{16'h0000, 16'h7FFF, 16'h8000, 16'h9FFF, 16'hA000,
                                16'hBFFF, 16'hC000, 16'hFDFF, 16'hFE00, 16'hFE9F,
                                16'hFEA0, 16'hFF80};
      foreach (pts[i]) begin
         bit lk;
         cpu_addr_i = pts[i];
         #0.4;
         lk = act && exp_lock(pts[i], src, newer);
         chk(req, "cpu_locked", 32'(cpu_locked_o), 32'(lk));
         chk("R9", "cpu_rdata", 32'(cpu_rdata_o), lk ? 32'hFF : 32'h3C);
         chk("R9", "cpu_wr", 32'(cpu_wr_o), 32'(!lk));
      end
   endtask

   task automatic wait_idle();
      for (int n = 0; n < 1000 && busy_o; n++) @(negedge clk);
   endtask

   initial begin
      #1_000_000;
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R4", "reset busy", 32'(busy_o), 0);
      chk("R2", "reset we", 32'(oam_we_o), 0);
      chk("R2", "reset req", 32'(bus_req_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: over-range start while idle does nothing
      kick(16'hF101);
      for (int c = 0; c < 20; c++) begin
         chk("R1", "idle reject busy", 32'(busy_o), 0);
         chk("R1", "idle reject we", 32'(oam_we_o), 0);
         @(negedge clk);
      end

      // R2 R3 R4: full copies from several bases, including the top limit
      kick(16'hC000);  run_sched(16'hC000, 0, LAST_W + 4, -1);
      kick(16'hF100);  run_sched(16'hF100, 0, LAST_W + 4, -1);
      // R1: over-range start mid-copy leaves the schedule unchanged
      kick(16'h4321);  run_sched(16'h4321, 0, LAST_W + 4, 30);

      // R5: restart during a write cycle
      kick(16'h8000);  run_sched(16'h8000, 0, 20, -1);
      chk("R5", "write in restart cycle", 32'(oam_we_o), 1);
      chk("R5", "old index", 32'(oam_addr_o), 3);
      kick(16'h1200);  run_sched(16'h1200, 0, LAST_W + 4, -1);

      // R5: restart sampled at the end of a request cycle
      kick(16'h2000);  run_sched(16'h2000, 0, 7, -1);
      chk("R5", "request before restart", 32'(bus_req_o), 1);
      kick(16'h3300);
      chk("R5", "dropped write", 32'(oam_we_o), 0);
      run_sched(16'h3300, 0, LAST_W + 4, -1);

      // R6 R7 R8 R9: lock table sweep over all source regions, both models
      for (int m = 0; m < 2; m++) begin
         for (int r = 0; r < 8; r++) begin
            logic [15:0] b;
            b = 16'(r * 'h2000);
            model_new_i = m[0];
            kick(b);
            @(posedge clk); #1;
            probe_set(b, m[0], 1'b1, m ? "R8" : "R7");
            probe_set(b, m[0], 1'b1, "R6");
            @(negedge clk);
            wait_idle();
            probe_set(b, m[0], 1'b0, "R9");
         end
      end

      // R10: window follows the advancing source (0x9FF0 crosses into 0xA000)
      model_new_i = 1'b0;
      @(negedge clk);
      kick(16'h9FF0);
      repeat (2) @(negedge clk);
      cpu_addr_i = 16'h8000; #0.4;
      chk("R10", "early 0x8000", 32'(cpu_locked_o), 1);
      cpu_addr_i = 16'hA000; #0.4;
      chk("R10", "early 0xA000", 32'(cpu_locked_o), 0);
      repeat (70) @(negedge clk);   // 16 requests done by cycle 68
      cpu_addr_i = 16'h8000; #0.4;
      chk("R10", "late 0x8000", 32'(cpu_locked_o), 0);
      cpu_addr_i = 16'hA000; #0.4;
      chk("R10", "late 0xA000", 32'(cpu_locked_o), 1);
      wait_idle();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule